// File: doc/BRIEF.md
# Product-Term Array Slice for a Macrocell Pair

This block is the programmable AND-OR plane that serves two neighbouring macrocells. It takes the input vector of the logic array and forms a true literal and a complement literal from each bit. It then computes a fixed bank of AND product terms, and each term's fuse mask selects which literals it uses. Sixteen of the terms are control terms, eight for each macrocell. The other sixteen are split between the two sum-of-products ORs that feed the macrocells' state registers, and the split is fixed by a parameter.

The fuse masks sit in one long shift register that is loaded serially while programming is enabled. The outputs are forced to 0 while programming is enabled and stay at 0 until one complete map has been shifted in. After that the array is purely combinational from `array_in` to the outputs.

Top module: `pt_pair_slice`

## Requirements
- R1: Array column 2i carries `array_in[i]` and column 2i+1 carries its complement. Each term is the AND of the columns whose fuse bit is 1.
- R2: A term with no fuse bit set evaluates to 1.
- R3: A term that connects both columns of the same input evaluates to 0 for every input value.
- R4: Terms 0 to 7 drive `ctrl_a` bits 0 to 7 and terms 8 to 15 drive `ctrl_b` bits 0 to 7. Within each byte the bit order is: output-register set, output-register reset, output-register clock, input-register set, input-register reset, input-register clock, output enable, XOR term.
- R5: With the default `SUM_A_TERMS` = 4, terms 16 to 19 are ORed into `sum_a` and terms 20 to 31 into `sum_b`. The allowed split values are 4, 6, 8, 10 and 12.
- R6: While `prog_en` is 1, each cycle with `prog_shift` = 1 shifts `prog_bit` into the map. After 1984 shifts, the first bit shifted in holds term 31 column 61 and the last holds term 0 column 0. Map bit index = term·62 + column.
- R7: All outputs are 0 while `prog_en` is 1.
- R8: Each rising edge of `prog_en` restarts the shift count. If fewer than 1984 shifts have followed it, the outputs stay 0 after `prog_en` returns to 0.
- R9: `prog_shift` pulses while `prog_en` is 0 do not change the loaded map.
- R10: A synchronous active-low reset clears the map and the shift count, and all outputs are 0 until the next complete load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_en | input | 1 | Programming enable; disables the array while 1 |
| prog_shift | input | 1 | Shift strobe for the fuse map |
| prog_bit | input | 1 | Serial fuse data |
| array_in | input | 31 | Array signal inputs |
| ctrl_a | output | 8 | Control terms of macrocell A |
| ctrl_b | output | 8 | Control terms of macrocell B |
| sum_a | output | 1 | Sum-of-products for macrocell A |
| sum_b | output | 1 | Sum-of-products for macrocell B |

## Verification
If a fuse bit is misplaced or the shift order is wrong, a term reads the wrong literal. This shows up as a wrong bit in `ctrl_a`, `ctrl_b` or a sum for the input vectors that separate those literals, and it is visible the moment the load completes. A fault in the shift count shows up right at the end of a load. If the count is short, the outputs come alive after a partial load. If the count never finishes, they stay 0 after a full load. A wrong split boundary moves a term from one sum to the other. Terms 19 and 20 are therefore each loaded as the only live term.

// File: rtl/pt_pkg.sv
// Shared constants and the role order of the eight control terms of one macrocell.
// Assumes a control byte is indexed by these role values.
package pt_pkg;
    typedef enum logic [2:0] {
        ROLE_OUT_SET   = 3'd0,
        ROLE_OUT_RESET = 3'd1,
        ROLE_OUT_CLK   = 3'd2,
        ROLE_IN_SET    = 3'd3,
        ROLE_IN_RESET  = 3'd4,
        ROLE_IN_CLK    = 3'd5,
        ROLE_OE        = 3'd6,
        ROLE_XOR       = 3'd7
    } ctrl_role_e;

    localparam int unsigned CTRL_ROLES = 8;
endpackage

// File: rtl/pt_fuse_loader.sv
// Serial fuse-map store. While prog_en is high each prog_shift shifts one bit in at index 0.
// It counts the shifts made since prog_en last rose and reports loaded once a full map is in
// and prog_en is low. Assumes prog_bit is valid in every cycle where prog_shift is 1.
module pt_fuse_loader #(
    parameter int unsigned MAP_BITS = 1984
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                prog_en,
    input  logic                prog_shift,
    input  logic                prog_bit,
    output logic [MAP_BITS-1:0] fuse_map,
    output logic                loaded
);
    localparam int unsigned CNT_W = $clog2(MAP_BITS + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(MAP_BITS);

    logic [CNT_W-1:0] shift_cnt;
    logic             prog_en_q;

    // Shift the map and keep the count of shifts since prog_en rose.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fuse_map  <= '0;
            shift_cnt <= '0;
            prog_en_q <= 1'b0;
        end else begin
            prog_en_q <= prog_en;
            if (prog_en && prog_shift) begin
                fuse_map <= {fuse_map[MAP_BITS-2:0], prog_bit};
            end
            if (prog_en && !prog_en_q) begin
                shift_cnt <= prog_shift ? CNT_W'(1) : '0;
            end else if (prog_en && prog_shift && shift_cnt != FULL) begin
                shift_cnt <= shift_cnt + CNT_W'(1);
            end
        end
    end

    // The array is live only with a complete map and programming off.
    always_comb loaded = !prog_en && (shift_cnt == FULL);
endmodule

// File: rtl/pt_literal_gen.sv
// Builds the literal columns: column 2i is input i and column 2i+1 is its complement.
// Purely combinational.
module pt_literal_gen #(
    parameter int unsigned N_IN = 31
) (
    input  logic [N_IN-1:0]   sig_in,
    output logic [2*N_IN-1:0] lits
);
    for (genvar i = 0; i < N_IN; i++) begin : g_lit
        assign lits[2*i]   = sig_in[i];
        assign lits[2*i+1] = ~sig_in[i];
    end
endmodule

// File: rtl/pt_term_array.sv
// Programmable AND plane. Term t takes the AND of the literal columns whose fuse bit
// (t*N_COL + column) is 1. A term with an empty mask gives 1, and a mask that holds
// both polarities of one input gives 0.
module pt_term_array #(
    parameter int unsigned N_COL  = 62,
    parameter int unsigned N_TERM = 32
) (
    input  logic [N_COL-1:0]        lits,
    input  logic [N_TERM*N_COL-1:0] fuse_map,
    output logic [N_TERM-1:0]       terms
);
    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        logic [N_COL-1:0] mask;
        assign mask     = fuse_map[t*N_COL +: N_COL];
        assign terms[t] = &(~mask | lits);
    end
endmodule

// File: rtl/pt_router.sv
// Routes terms to the outputs. The first N_CTRL terms go to cell A's control byte and the
// next N_CTRL to cell B's. SUM_A terms are ORed into sum_a and the remainder into sum_b.
// Everything is forced to 0 when active is low. Assumes 0 < SUM_A < N_SUM.
module pt_router #(
    parameter int unsigned N_CTRL = 8,
    parameter int unsigned N_SUM  = 16,
    parameter int unsigned SUM_A  = 4
) (
    input  logic [2*N_CTRL+N_SUM-1:0] terms,
    input  logic                      active,
    output logic [N_CTRL-1:0]         ctrl_a,
    output logic [N_CTRL-1:0]         ctrl_b,
    output logic                      sum_a,
    output logic                      sum_b
);
    localparam int unsigned BASE_A = 2 * N_CTRL;
    localparam int unsigned BASE_B = BASE_A + SUM_A;
    localparam int unsigned SUM_B  = N_SUM - SUM_A;

    // Gate the control bytes and the two sums by the active flag.
    always_comb begin
        ctrl_a = active ? terms[N_CTRL-1:0]      : '0;
        ctrl_b = active ? terms[N_CTRL +: N_CTRL] : '0;
        sum_a  = active & (|terms[BASE_A +: SUM_A]);
        sum_b  = active & (|terms[BASE_B +: SUM_B]);
    end
endmodule

// File: rtl/pt_pair_slice.sv
// Product-term array slice for one macrocell pair: literal generation, a fused AND plane,
// a fixed routing of control terms, and an uneven split of the shared sum terms.
// Assumes the fuse map is loaded serially before use and that array_in is settled
// wherever the outputs are consumed.
module pt_pair_slice #(
    parameter int unsigned N_IN        = 31,
    parameter int unsigned N_CTRL      = pt_pkg::CTRL_ROLES,
    parameter int unsigned N_SUM       = 16,
    parameter int unsigned SUM_A_TERMS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  logic              prog_shift,
    input  logic              prog_bit,
    input  logic [N_IN-1:0]   array_in,
    output logic [N_CTRL-1:0] ctrl_a,
    output logic [N_CTRL-1:0] ctrl_b,
    output logic              sum_a,
    output logic              sum_b
);
    localparam int unsigned N_COL    = 2 * N_IN;
    localparam int unsigned N_TERM   = 2 * N_CTRL + N_SUM;
    localparam int unsigned MAP_BITS = N_TERM * N_COL;

    logic [MAP_BITS-1:0] fuse_map;
    logic                loaded;
    logic [N_COL-1:0]    lits;
    logic [N_TERM-1:0]   terms;

    pt_fuse_loader #(.MAP_BITS(MAP_BITS)) u_loader (
        .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .prog_shift(prog_shift),
        .prog_bit(prog_bit), .fuse_map(fuse_map), .loaded(loaded)
    );

    pt_literal_gen #(.N_IN(N_IN)) u_lits (
        .sig_in(array_in), .lits(lits)
    );

    pt_term_array #(.N_COL(N_COL), .N_TERM(N_TERM)) u_terms (
        .lits(lits), .fuse_map(fuse_map), .terms(terms)
    );

    pt_router #(.N_CTRL(N_CTRL), .N_SUM(N_SUM), .SUM_A(SUM_A_TERMS)) u_route (
        .terms(terms), .active(loaded),
        .ctrl_a(ctrl_a), .ctrl_b(ctrl_b), .sum_a(sum_a), .sum_b(sum_b)
    );
endmodule

// File: rtl/pt_pair_slice_chk.sv
// Assertion checker for pt_pair_slice, attached with bind. It watches the outputs against
// programming state and the shift behaviour of the fuse map.
module pt_pair_slice_chk #(
    parameter int unsigned N_CTRL   = 8,
    parameter int unsigned MAP_BITS = 1984
) (
    input logic                clk,
    input logic                rst_n,
    input logic                prog_en,
    input logic                prog_shift,
    input logic                prog_bit,
    input logic [N_CTRL-1:0]   ctrl_a,
    input logic [N_CTRL-1:0]   ctrl_b,
    input logic                sum_a,
    input logic                sum_b,
    input logic [MAP_BITS-1:0] fuse_map,
    input logic                loaded
);
    assert_quiet_in_prog_R7: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en |-> (ctrl_a == '0 && ctrl_b == '0 && !sum_a && !sum_b));

    assert_quiet_unloaded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !loaded |-> (ctrl_a == '0 && ctrl_b == '0 && !sum_a && !sum_b));

    assert_shift_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_en && prog_shift) |=> fuse_map[0] == $past(prog_bit));

    assert_shift_chain_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_en && prog_shift) |=> fuse_map[MAP_BITS-1:1] == $past(fuse_map[MAP_BITS-2:0]));

    assert_map_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_en |=> $stable(fuse_map));
endmodule

bind pt_pair_slice pt_pair_slice_chk #(.N_CTRL(N_CTRL), .MAP_BITS(MAP_BITS)) i_chk (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .prog_shift(prog_shift),
    .prog_bit(prog_bit), .ctrl_a(ctrl_a), .ctrl_b(ctrl_b), .sum_a(sum_a),
    .sum_b(sum_b), .fuse_map(fuse_map), .loaded(loaded)
);

// File: tb/test_pt_pair_slice.sv
module test_pt_pair_slice;
    localparam int N_IN = 31;
    localparam int N_COL = 62;
    localparam int N_TERM = 32;
    localparam int MAP_BITS = N_TERM * N_COL;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic prog_en = 1'b0;
    logic prog_shift = 1'b0;
    logic prog_bit = 1'b0;
    logic [N_IN-1:0] array_in = '0;
    logic [7:0] ctrl_a, ctrl_b;
    logic sum_a, sum_b;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [N_COL-1:0] msk [N_TERM];
    logic [MAP_BITS-1:0] map_img;

    always #5 clk = ~clk;

    pt_pair_slice i_pt_pair_slice (
        .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .prog_shift(prog_shift),
        .prog_bit(prog_bit), .array_in(array_in), .ctrl_a(ctrl_a), .ctrl_b(ctrl_b),
        .sum_a(sum_a), .sum_b(sum_b)
    );

    // Stimulus {array_in, ctrl_a, ctrl_b, sum_a, sum_b} for fuse map A.
    localparam logic [48:0] VECS [6] = '{
        {31'h0000_0000, 8'h4A, 8'h7E, 1'b0, 1'b0},
        {31'h7FFF_FFFF, 8'hAD, 8'h7F, 1'b1, 1'b0},
        {31'h0000_2005, 8'h0F, 8'h7E, 1'b0, 1'b1},
        {31'h4000_0422, 8'hA8, 8'h7F, 1'b0, 1'b0},
        {31'h0000_3C00, 8'h4A, 8'h7E, 1'b1, 1'b0},
        {31'h0000_2804, 8'h4A, 8'h7E, 1'b0, 1'b1}
    };

    task automatic check(input string req, input logic [17:0] got, input logic [17:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [17:0] outs();
        return {ctrl_a, ctrl_b, sum_a, sum_b};
    endfunction

    function automatic logic [N_COL-1:0] col(input int c);
        return N_COL'(1) << c;
    endfunction

    task automatic flatten();
        for (int t = 0; t < N_TERM; t++) map_img[t*N_COL +: N_COL] = msk[t];
    endtask

    // Shift the image in, highest index first, then drop prog_en.
    task automatic load_map(input int nbits);
        @(negedge clk);
        prog_en = 1'b1;
        for (int i = MAP_BITS - 1; i >= MAP_BITS - nbits; i--) begin
            prog_bit = map_img[i];
            prog_shift = 1'b1;
            @(negedge clk);
        end
        prog_shift = 1'b0;
        prog_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic all_contra();
        for (int t = 0; t < N_TERM; t++) msk[t] = col(18) | col(19);
    endtask

    initial begin
        #(100000 * 10);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R10: reset clears the map; outputs are 0 with all inputs high.
        array_in = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 reset", outs(), 18'h0);

        // Fuse map A.
        for (int t = 0; t < N_TERM; t++) msk[t] = '0;
        msk[0] = col(0);
        msk[1] = col(3);
        msk[2] = col(0) | col(4);
        msk[4] = col(6) | col(7);
        msk[5] = col(60);
        msk[6] = col(1) | col(61);
        msk[7] = col(10);
        msk[8] = col(2);
        msk[15] = col(58) | col(59);
        msk[16] = col(20) | col(22);
        for (int t = 17; t < 31; t++) msk[t] = col(18) | col(19);
        msk[31] = col(25) | col(26);
        flatten();

        // R8: a partial load leaves the outputs at 0.
        load_map(100);
        check("R8 partial load", outs(), 18'h0);

        // R6: full load; then walk the table (R1 R2 R3 R4 R5).
        load_map(MAP_BITS);
        for (int v = 0; v < 6; v++) begin
            array_in = VECS[v][48:18];
            #1;
            check($sformatf("R1/R4/R5/R6 vector %0d", v), outs(), VECS[v][17:0]);
        end

        // R9: shift pulses with prog_en low change nothing.
        prog_bit = 1'b1;
        prog_shift = 1'b1;
        repeat (10) @(negedge clk);
        prog_shift = 1'b0;
        array_in = VECS[2][48:18];
        @(negedge clk);
        check("R9 shift ignored", outs(), VECS[2][17:0]);

        // R7: raising prog_en silences the loaded array at once.
        array_in = '1;
        prog_en = 1'b1;
        #1;
        check("R7 prog_en high", outs(), 18'h0);
        @(negedge clk);
        check("R7 prog_en held", outs(), 18'h0);
        prog_en = 1'b0;
        @(negedge clk);

        // R2: an all-empty map makes every term 1.
        for (int t = 0; t < N_TERM; t++) msk[t] = '0;
        flatten();
        load_map(MAP_BITS);
        array_in = 31'h1234_5678;
        #1;
        check("R2 empty terms", outs(), {8'hFF, 8'hFF, 1'b1, 1'b1});

        // R5 and R3: only term 19 is live, so it lands in sum_a.
        all_contra();
        msk[19] = '0;
        flatten();
        load_map(MAP_BITS);
        array_in = '1;
        #1;
        check("R5 term 19 to sum_a, R3 zero", outs(), {8'h00, 8'h00, 1'b1, 1'b0});

        // R5: only term 20 is live, so it lands in sum_b.
        all_contra();
        msk[20] = '0;
        flatten();
        load_map(MAP_BITS);
        array_in = '0;
        #1;
        check("R5 term 20 to sum_b", outs(), {8'h00, 8'h00, 1'b0, 1'b1});

        // R10: a reset after a load silences the outputs again.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 reset after load", outs(), 18'h0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule